// File: doc/BRIEF.md
# Multi-Polynomial Byte-Serial CRC Engine

This block keeps a running cyclic redundancy checksum over data that software writes through a small synchronous register port. A control register picks one of three generator polynomials (two 16-bit, one 32-bit) and switches on optional transforms. On the data side these are per-byte bit mirroring, reversal of byte order and inversion. On the checksum side they are full-width bit mirroring, byte swapping and inversion, and the two sides are set independently. Writing the seed register sets the starting remainder and commits the polynomial choice.

Data writes may carry one, two or four bytes. The engine folds one byte per clock into the remainder, most significant bit first, so a write of n bytes keeps it busy for n cycles. A new data write is taken while at most one byte is still pending, so single-byte writes stream at one per clock. A write that cannot be taken yet is held off with a low ready signal and is not lost.

Top module: `crc_engine`

## Requirements
- R1: Control bits [1:0] select the polynomial: 00 gives 0x8005 (16-bit), 01 gives 0x1021 (16-bit), and 10 or 11 gives 0x04C11DB7 (32-bit). In the 16-bit modes the checksum read has bits [31:16] at zero.
- R2: A write to address 1 (seed) loads the remainder with wdata, or with wdata[15:0] in a 16-bit mode, and latches the polynomial field then held in control. A later change of control bits [1:0] does not alter the polynomial or width in use until the next seed write.
- R3: A write to address 2 (data) with wsize 00, 01 or 10/11 feeds the low 1, 2 or 4 bytes of wdata. Byte 0 goes first and each byte enters MSB first with no reflection. The remainder does not change when no byte is pending and no seed write is taken.
- R4: Data-side transforms, applied to each written byte before it enters: control bit 3 mirrors the bits within each byte, control bit 4 reverses the order in which the written bytes are consumed, and control bit 2 inverts them.
- R5: The checksum is read at address 3. Control bit 6 mirrors all 16 or 32 bits, then control bit 7 reverses the 2 or 4 bytes, then control bit 5 inverts the result. Changes to these bits take effect at once.
- R6: A data write of n bytes occupies the engine for the n cycles after it is taken, and busy is high exactly while bytes are pending. A four-byte write keeps busy high for 4 cycles.
- R7: wready is high for a data write while at most one byte is pending, and high for any other address only when none is pending. While wready is low, wr_en has no effect; a held write is taken once wready rises.
- R8: After reset, control reads 0, the remainder is 0, the polynomial is 0x8005, busy is low and wready is high.
- R9: Address 0 reads the control value in bits [7:0], with zeros above. Addresses 1 and 2 read zero.
- R10: Known values: mode 01, seed 0xFFFF, no transforms over "123456789" gives 0x29B1. Mode 00, seed 0 gives 0xFEE8. Mode 10, seed 0xFFFFFFFF, with data bit mirroring plus checksum mirroring and inversion, gives 0xCBF43926.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request; held until taken |
| addr | input | ADDR_W (2) | Register address: 0 control, 1 seed, 2 data, 3 checksum |
| wdata | input | BUS_W (32) | Write data |
| wsize | input | 2 | Data write size: 00 byte, 01 half-word, 10/11 word |
| wready | output | 1 | Write taken on this edge when high with wr_en |
| busy | output | 1 | Bytes pending in the engine |
| rdata | output | BUS_W (32) | Combinational read of the addressed register |

## Verification
The bench builds the engine with its default parameters: a 32-bit bus and the three standard polynomials. This brings every polynomial, every write size and the full four-byte pipeline occupancy within reach, along with each data-side and checksum-side transform. A behavioural queue model predicts busy, wready and the read value on every cycle. It exercises streamed single-byte writes, stalled word and seed writes, polynomial changes made without a seed load, and the three published check strings, including the 32-bit check fed with reversed byte order.

// File: rtl/crc_pkg.sv
package crc_pkg;

   localparam int unsigned BYTE_W = 8;

   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_SEED = 2'd1;
   localparam logic [1:0] A_DATA = 2'd2;
   localparam logic [1:0] A_SUM  = 2'd3;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'b00,
      SZ_HALF  = 2'b01,
      SZ_WORD  = 2'b10,
      SZ_WORDX = 2'b11
   } wsize_t;

   typedef enum logic [1:0] {
      MD_CRC16  = 2'b00,
      MD_CCITT  = 2'b01,
      MD_CRC32  = 2'b10,
      MD_CRC32X = 2'b11
   } mode_t;

   typedef struct packed {
      logic  sum_swap;
      logic  sum_flip;
      logic  sum_inv;
      logic  dat_swap;
      logic  dat_flip;
      logic  dat_inv;
      mode_t mode;
   } ctrl_t;

   function automatic logic [BYTE_W-1:0] flip_byte(input logic [BYTE_W-1:0] b);
      logic [BYTE_W-1:0] r;
      for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
      return r;
   endfunction

endpackage

// File: rtl/crc_data_xform.sv
module crc_data_xform
   import crc_pkg::*;
#(
   parameter int unsigned BUS_W = 32,
   localparam int unsigned LANES = BUS_W / BYTE_W,
   localparam int unsigned CNT_W = $clog2(LANES + 1)
) (
   input  logic [BUS_W-1:0] wdata_i,
   input  logic [1:0]       size_i,
   input  logic             inv_i,
   input  logic             flip_i,
   input  logic             swap_i,
   output logic [BUS_W-1:0] bytes_o,
   output logic [CNT_W-1:0] count_o
);

   logic [BUS_W-1:0] flipped;
   logic [BUS_W-1:0] ordered;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign flipped[g*BYTE_W +: BYTE_W] = flip_i ? flip_byte(wdata_i[g*BYTE_W +: BYTE_W])
                                                     : wdata_i[g*BYTE_W +: BYTE_W];
      end
   endgenerate

   always_comb begin
      ordered = flipped;
      if (swap_i) begin
         unique case (size_i)
            SZ_BYTE: ordered = flipped;
            SZ_HALF: ordered = {flipped[BUS_W-1:2*BYTE_W], flipped[BYTE_W-1:0],
                                flipped[2*BYTE_W-1:BYTE_W]};
            default: begin
               for (int i = 0; i < LANES; i++)
                  ordered[i*BYTE_W +: BYTE_W] = flipped[(LANES-1-i)*BYTE_W +: BYTE_W];
            end
         endcase
      end
   end

   assign bytes_o = inv_i ? ~ordered : ordered;
   assign count_o = (size_i == SZ_BYTE) ? CNT_W'(1) :
                    (size_i == SZ_HALF) ? CNT_W'(2) : CNT_W'(LANES);

endmodule

// File: rtl/crc_lfsr_byte.sv
module crc_lfsr_byte
   import crc_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0]      state_i,
   input  logic [W-1:0]      poly_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic [W-1:0]      next_o
);

   logic [W-1:0] acc;
   logic         fb;

   always_comb begin
      acc = state_i;
      fb  = 1'b0;
      for (int i = BYTE_W - 1; i >= 0; i--) begin
         fb  = acc[W-1] ^ byte_i[i];
         acc = {acc[W-2:0], 1'b0} ^ (fb ? poly_i : '0);
      end
      next_o = acc;
   end

endmodule

// File: rtl/crc_sum_xform.sv
module crc_sum_xform
   import crc_pkg::*;
#(
   parameter int unsigned W = 16,
   localparam int unsigned NB = W / BYTE_W
) (
   input  logic [W-1:0] raw_i,
   input  logic         flip_i,
   input  logic         swap_i,
   input  logic         inv_i,
   output logic [W-1:0] sum_o
);

   logic [W-1:0] mirrored;
   logic [W-1:0] swapped;
   logic [W-1:0] stage1;
   logic [W-1:0] stage2;

   generate
      for (genvar g = 0; g < W; g++) begin : g_bit
         assign mirrored[g] = raw_i[W-1-g];
      end
      for (genvar g = 0; g < NB; g++) begin : g_byte
         assign swapped[g*BYTE_W +: BYTE_W] = stage1[(NB-1-g)*BYTE_W +: BYTE_W];
      end
   endgenerate

   assign stage1 = flip_i ? mirrored : raw_i;
   assign stage2 = swap_i ? swapped : stage1;
   assign sum_o  = inv_i ? ~stage2 : stage2;

endmodule

// File: rtl/crc_engine.sv
module crc_engine
   import crc_pkg::*;
#(
   parameter int unsigned BUS_W  = 32,
   parameter int unsigned ADDR_W = 2,
   parameter logic [15:0] POLY_A = 16'h8005,
   parameter logic [15:0] POLY_B = 16'h1021,
   parameter logic [31:0] POLY_C = 32'h04C11DB7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic [1:0]        wsize,
   output logic              wready,
   output logic              busy,
   output logic [BUS_W-1:0]  rdata
);

   localparam int unsigned LANES  = BUS_W / BYTE_W;
   localparam int unsigned CNT_W  = $clog2(LANES + 1);
   localparam int unsigned CRC_W  = 32;
   localparam int unsigned HALF_W = 16;

   generate
      if (BUS_W != CRC_W) begin : g_bad_bus
         $error("crc_engine: BUS_W must equal 32");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("crc_engine: ADDR_W must be at least 2");
      end
   endgenerate

   ctrl_t             ctrl_q;
   mode_t             mode_q;
   logic [CRC_W-1:0]  state_q;
   logic [BUS_W-1:0]  buf_q;
   logic [CNT_W-1:0]  pend_q;

   logic [BUS_W-1:0]  xf_bytes;
   logic [CNT_W-1:0]  xf_count;
   logic [HALF_W-1:0] step16;
   logic [CRC_W-1:0]  step32;
   logic [CRC_W-1:0]  next_crc;
   logic [HALF_W-1:0] sum16;
   logic [CRC_W-1:0]  sum32;
   logic [CRC_W-1:0]  sum_sel;
   logic              wide;
   logic              take;

   assign wide   = mode_q[1];
   assign busy   = (pend_q != '0);
   assign wready = (addr == ADDR_W'(A_DATA)) ? (pend_q <= CNT_W'(1)) : (pend_q == '0);
   assign take   = wr_en & wready;

   crc_data_xform #(.BUS_W(BUS_W)) u_dxf (
      .wdata_i (wdata),
      .size_i  (wsize),
      .inv_i   (ctrl_q.dat_inv),
      .flip_i  (ctrl_q.dat_flip),
      .swap_i  (ctrl_q.dat_swap),
      .bytes_o (xf_bytes),
      .count_o (xf_count)
   );

   crc_lfsr_byte #(.W(HALF_W)) u_step16 (
      .state_i (state_q[HALF_W-1:0]),
      .poly_i  ((mode_q == MD_CCITT) ? POLY_B : POLY_A),
      .byte_i  (buf_q[BYTE_W-1:0]),
      .next_o  (step16)
   );

   crc_lfsr_byte #(.W(CRC_W)) u_step32 (
      .state_i (state_q),
      .poly_i  (POLY_C),
      .byte_i  (buf_q[BYTE_W-1:0]),
      .next_o  (step32)
   );

   assign next_crc = wide ? step32 : {{(CRC_W-HALF_W){1'b0}}, step16};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         mode_q  <= MD_CRC16;
         state_q <= '0;
         buf_q   <= '0;
         pend_q  <= '0;
      end else begin
         if (busy) begin
            state_q <= next_crc;
            buf_q   <= buf_q >> BYTE_W;
            pend_q  <= pend_q - CNT_W'(1);
         end
         if (take) begin
            if (addr == ADDR_W'(A_CTRL)) begin
               ctrl_q <= ctrl_t'(wdata[7:0]);
            end else if (addr == ADDR_W'(A_SEED)) begin
               mode_q  <= ctrl_q.mode;
               state_q <= ctrl_q.mode[1] ? wdata[CRC_W-1:0]
                                         : {{(CRC_W-HALF_W){1'b0}}, wdata[HALF_W-1:0]};
            end else if (addr == ADDR_W'(A_DATA)) begin
               buf_q  <= xf_bytes;
               pend_q <= xf_count;
            end
         end
      end
   end

   crc_sum_xform #(.W(HALF_W)) u_sum16 (
      .raw_i  (state_q[HALF_W-1:0]),
      .flip_i (ctrl_q.sum_flip),
      .swap_i (ctrl_q.sum_swap),
      .inv_i  (ctrl_q.sum_inv),
      .sum_o  (sum16)
   );

   crc_sum_xform #(.W(CRC_W)) u_sum32 (
      .raw_i  (state_q),
      .flip_i (ctrl_q.sum_flip),
      .swap_i (ctrl_q.sum_swap),
      .inv_i  (ctrl_q.sum_inv),
      .sum_o  (sum32)
   );

   assign sum_sel = wide ? sum32 : {{(CRC_W-HALF_W){1'b0}}, sum16};

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(A_CTRL))
         rdata[7:0] = ctrl_q;
      else if (addr == ADDR_W'(A_SUM))
         rdata = BUS_W'(sum_sel);
   end

endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk
   import crc_pkg::*;
#(
   parameter int unsigned BUS_W  = 32,
   parameter int unsigned ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [BUS_W-1:0]  wdata,
   input logic [1:0]        wsize,
   input logic              wready,
   input logic              busy,
   input logic [BUS_W-1:0]  rdata,
   input logic [7:0]        ctrl_q,
   input logic [1:0]        mode_q,
   input logic [31:0]       state_q
);

   logic seed_take;
   logic word_take;
   logic other_take;

   assign seed_take  = wr_en && wready && (addr == ADDR_W'(A_SEED));
   assign word_take  = wr_en && wready && (addr == ADDR_W'(A_DATA)) && wsize[1];
   assign other_take = wr_en && wready && (addr != ADDR_W'(A_CTRL));

   AST_SEED_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      seed_take |=> state_q == ($past(ctrl_q[1]) ? $past(wdata[31:0])
                                                 : {16'h0000, $past(wdata[15:0])})); // R2

   AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !seed_take |=> $stable(mode_q)); // R2

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q[1] && addr == ADDR_W'(A_SUM)) |-> rdata[31:16] == 16'h0000); // R1

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !other_take) |=> $stable(state_q)); // R3

   AST_WORD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      word_take |-> ##4 busy); // R6

   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> wready); // R7

endmodule

bind crc_engine crc_engine_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .addr    (addr),
   .wdata   (wdata),
   .wsize   (wsize),
   .wready  (wready),
   .busy    (busy),
   .rdata   (rdata),
   .ctrl_q  (ctrl_q),
   .mode_q  (mode_q),
   .state_q (state_q)
);

// File: tb/sim_crc_engine.sv
`timescale 1ns/1ps
module sim_crc_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = '0;
   logic [1:0]  wsize = 2'd0;
   logic        wready;
   logic        busy;
   logic [31:0] rdata;

   int n_cmp = 0;
   int n_bad = 0;
   bit cmp_on = 1'b0;
   bit done = 1'b0;

   // behavioural model
   logic [31:0] m_state = '0;
   logic [7:0]  m_ctrl = '0;
   logic [1:0]  m_mode = '0;
   logic [7:0]  m_q[$];
   bit          m_acc = 1'b0;

   crc_engine u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .wsize(wsize), .wready(wready), .busy(busy), .rdata(rdata)
   );

   always #10 clk = ~clk;

   function automatic logic [31:0] ref_step(input logic [31:0] s, input logic [7:0] b,
                                            input logic [1:0] md);
      int          w    = md[1] ? 32 : 16;
      logic [31:0] p    = md[1] ? 32'h04C11DB7 : ((md == 2'b01) ? 32'h1021 : 32'h8005);
      logic [31:0] mask = md[1] ? 32'hFFFFFFFF : 32'h0000FFFF;
      for (int i = 7; i >= 0; i--) begin
         logic fb;
         fb = s[w-1] ^ b[i];
         s  = (s << 1) & mask;
         if (fb) s = s ^ p;
      end
      return s;
   endfunction

   function automatic logic [31:0] ref_sum();
      int          w = m_mode[1] ? 32 : 16;
      logic [31:0] v = m_state;
      logic [31:0] t;
      if (m_ctrl[6]) begin
         t = '0;
         for (int i = 0; i < w; i++) t[i] = v[w-1-i];
         v = t;
      end
      if (m_ctrl[7]) begin
         t = '0;
         for (int i = 0; i < w/8; i++) t[i*8 +: 8] = v[(w/8-1-i)*8 +: 8];
         v = t;
      end
      if (m_ctrl[5]) v = ~v;
      if (w == 16) v = v & 32'h0000FFFF;
      return v;
   endfunction

   function automatic bit ref_ready(input logic [1:0] a);
      return (a == 2'd2) ? (m_q.size() <= 1) : (m_q.size() == 0);
   endfunction

   function automatic logic [31:0] ref_rdata(input logic [1:0] a);
      if (a == 2'd0) return {24'h0, m_ctrl};
      if (a == 2'd3) return ref_sum();
      return 32'h0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = '0; m_ctrl = '0; m_mode = '0; m_q.delete(); m_acc = 1'b0;
      end else begin
         m_acc = wr_en && ref_ready(addr);
         if (m_q.size() > 0) m_state = ref_step(m_state, m_q.pop_front(), m_mode);
         if (m_acc) begin
            case (addr)
               2'd0: m_ctrl = wdata[7:0];
               2'd1: begin
                  m_mode  = m_ctrl[1:0];
                  m_state = m_mode[1] ? wdata : (wdata & 32'h0000FFFF);
               end
               2'd2: begin
                  int n;
                  logic [7:0] arr[4];
                  n = (wsize == 2'b00) ? 1 : (wsize == 2'b01) ? 2 : 4;
                  for (int i = 0; i < n; i++) begin
                     logic [7:0] b;
                     b = wdata[i*8 +: 8];
                     if (m_ctrl[3]) for (int k = 0; k < 8; k++) arr[i][k] = b[7-k];
                     else arr[i] = b;
                     if (m_ctrl[2]) arr[i] = ~arr[i];
                  end
                  for (int i = 0; i < n; i++) m_q.push_back(m_ctrl[4] ? arr[n-1-i] : arr[i]);
               end
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(posedge clk) begin
      #5;
      if (cmp_on && !done) begin
         chk("R6 busy", {31'h0, busy}, {31'h0, (m_q.size() != 0)});
         chk("R7 wready", {31'h0, wready}, {31'h0, ref_ready(addr)});
         chk((addr == 2'd3) ? "R5 checksum" : "R9 readback", rdata, ref_rdata(addr));
      end
   end

   // called at a falling edge; returns at the falling edge after acceptance
   task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [1:0] sz,
                     output int edges);
      addr = a; wdata = d; wsize = sz; wr_en = 1'b1;
      edges = 0;
      do begin
         @(negedge clk);
         edges++;
      end while (!m_acc);
   endtask

   task automatic idle(input int n);
      wr_en = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
      wr_en = 1'b0; addr = a;
      #2;
      chk(tag, rdata, exp);
   endtask

   task automatic feed_str(input logic [1:0] sz);
      int e;
      if (sz == 2'b00) begin
         for (int i = 0; i < 9; i++) wr(2'd2, 32'h31 + i, 2'b00, e);
      end else begin
         wr(2'd2, 32'h00003231, 2'b01, e);
         wr(2'd2, 32'h00003433, 2'b01, e);
         wr(2'd2, 32'h00003635, 2'b01, e);
         wr(2'd2, 32'h00003837, 2'b01, e);
         wr(2'd2, 32'h00000039, 2'b00, e);
      end
      idle(6);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int e;
      repeat (3) @(posedge clk);
      #2;
      addr = 2'd3;
      #1;
      chk("R8 reset checksum", rdata, 32'h0);
      chk("R8 reset busy", {31'h0, busy}, 32'h0);
      chk("R8 reset wready", {31'h0, wready}, 32'h1);
      addr = 2'd0;
      #1;
      chk("R8 reset ctrl", rdata, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      @(negedge clk);

      // R10 / R3: CCITT, byte writes streaming one per cycle (R6)
      wr(2'd0, 32'h01, 2'b00, e);
      wr(2'd1, 32'h0000FFFF, 2'b00, e);
      addr = 2'd2; wdata = 32'h31; wsize = 2'b00; wr_en = 1'b1;
      for (int i = 0; i < 9; i++) begin
         wdata = 32'h31 + i;
         @(negedge clk);
         chk("R6 byte stream taken each cycle", {31'h0, m_acc}, 32'h1);
      end
      idle(4);
      rd(2'd3, 32'h000029B1, "R10 ccitt check");

      // R10: CRC-16 0x8005 from seed 0, half-words
      wr(2'd0, 32'h00, 2'b00, e);
      wr(2'd1, 32'h0, 2'b00, e);
      feed_str(2'b01);
      rd(2'd3, 32'h0000FEE8, "R10 crc16 check");

      // R10: CRC-32 reflected check via words
      wr(2'd0, 32'h6A, 2'b00, e);
      wr(2'd1, 32'hFFFFFFFF, 2'b00, e);
      wr(2'd2, 32'h34333231, 2'b10, e);
      wr(2'd2, 32'h38373635, 2'b10, e);
      chk("R7 word stalled 4 edges", e, 4);
      wr(2'd2, 32'h00000039, 2'b00, e);
      idle(6);
      rd(2'd3, 32'hCBF43926, "R10 crc32 check");

      // R4: data byte reversal gives the same result for byte-swapped words
      wr(2'd0, 32'h7A, 2'b00, e);
      wr(2'd1, 32'hFFFFFFFF, 2'b00, e);
      wr(2'd2, 32'h31323334, 2'b11, e);
      wr(2'd2, 32'h35363738, 2'b10, e);
      wr(2'd2, 32'h00000039, 2'b00, e);
      idle(6);
      rd(2'd3, 32'hCBF43926, "R4 byte order reverse");

      // R6: busy length of one word write
      wr(2'd2, 32'hA5A55A5A, 2'b10, e);
      wr_en = 1'b0;
      begin
         int n = 0;
         while (busy && n < 10) begin n++; @(negedge clk); end
         chk("R6 word busy cycles", n, 4);
      end
      idle(2);

      // R7: seed write held off while a byte is pending
      wr(2'd2, 32'h000000C3, 2'b00, e);
      wr(2'd1, 32'h12345678, 2'b00, e);
      chk("R7 seed held", e, 2);
      idle(2);

      // R2 / R1: 16-bit seed masks, later mode change deferred
      wr(2'd0, 32'h01, 2'b00, e);
      wr(2'd1, 32'hABCD1234, 2'b00, e);
      idle(1);
      rd(2'd3, 32'h00001234, "R2 seed low half");
      wr(2'd0, 32'h02, 2'b00, e);
      idle(1);
      rd(2'd3, 32'h00001234, "R2 mode change deferred");
      wr(2'd2, 32'hDEADBEEF, 2'b10, e);
      idle(6);
      rd(2'd3, ref_sum() & 32'h0000FFFF, "R1 16-bit upper zero");
      wr(2'd1, 32'hABCD1234, 2'b00, e);
      idle(1);
      rd(2'd3, 32'hABCD1234, "R2 32-bit seed");

      // R4 / R5: mixed transforms and sizes, checked against the model
      for (int c = 0; c < 16; c++) begin
         logic [7:0] cv;
         cv = {c[3:0], 2'b00, c[1:0]} ^ {4'h0, c[3], c[2], 2'b00};
         wr(2'd0, {24'h0, cv}, 2'b00, e);
         wr(2'd1, 32'h5A5A0000 + c, 2'b00, e);
         wr(2'd2, 32'h01020304 * (c + 1), 2'(c), e);
         wr(2'd2, 32'hF0E1D2C3 ^ c, 2'b01, e);
         wr(2'd2, 32'h0BADC0DE + c, 2'b10, e);
         idle(6);
         rd(2'd3, ref_sum(), "R5 mixed transforms");
         rd(2'd0, {24'h0, cv}, "R9 ctrl readback");
         rd(2'd1, 32'h0, "R9 seed reads zero");
      end

      // R3: inverted data with R5 checksum swap
      wr(2'd0, 32'h86, 2'b00, e);
      wr(2'd1, 32'h00C0FFEE, 2'b00, e);
      wr(2'd2, 32'h00000077, 2'b00, e);
      idle(3);
      rd(2'd3, ref_sum(), "R3 single byte");

      idle(3);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule